// File: doc/BRIEF.md
# DMA Event Interrupt Controller

This block gathers the single-cycle event pulses that a multi-channel DMA engine produces and turns them into one interrupt line. There are five event kinds: whole-transfer done, block done, source-side transaction done, destination-side transaction done, and error. Each kind has a bank of per-channel latches. A latch sets on a pulse and stays set until software clears it. A per-channel mask decides which latched bits count as pending. The masked result of each bank is reduced to one summary bit per kind, and the summary bits are ORed into the interrupt.

Software reaches the banks through a small register port. A kind selector chooses one of four views (latched, pending, mask, clear) and a type selector chooses the event kind. Writes are qualified by a strobe. Reads are combinational.

Transaction-done events on the source side mean nothing when that side of the channel is plain memory. The same holds for the destination side. Two per-channel inputs flag memory endpoints, and pulses of the matching kind are discarded for those channels.

Top module: `dma_evt_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every latched bit and every mask bit is 0, so `evt_summary`, `irq` and all register reads are 0.
- R2: A pulse on `evt_pulse[k*NUM_CH+c]` sets latched bit c of kind k at the next rising edge, and the bit stays set without further pulses.
- R3: A write with `reg_kind`=3 (clear) and `reg_type`=k clears each latched bit of kind k whose `reg_wdata` bit is 1. Bits written 0 are untouched. A pulse on the same bit in the same cycle leaves it set.
- R4: A write with `reg_kind`=2 (mask) updates mask bit c of kind k to `reg_wdata[c]` only when enable bit `reg_wdata[NUM_CH+c]` is 1. Other mask bits keep their value.
- R5: The pending view of kind k (`reg_kind`=1) reads as latched AND mask for every channel bit.
- R6: Pulses of kind 2 (source transaction done) are discarded for channels with `src_is_mem` set. Pulses of kind 3 (destination transaction done) are discarded for channels with `dst_is_mem` set.
- R7: `evt_summary[k]` is the OR of the pending bits of kind k. Bit 0 is transfer done, 1 block done, 2 source transaction, 3 destination transaction, 4 error.
- R8: `irq` is 1 exactly when some bit of `evt_summary` is 1.
- R9: Register views are encoded as 0 latched, 1 pending, 2 mask, 3 clear. The clear view reads as 0. A `reg_type` of 5 or more reads as 0. Writes to the latched or pending view, or with `reg_type` of 5 or more, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | NUM_TYPES*NUM_CH | Event pulses, bit k*NUM_CH+c is kind k on channel c |
| src_is_mem | input | NUM_CH | Channel source side is memory |
| dst_is_mem | input | NUM_CH | Channel destination side is memory |
| reg_wr | input | 1 | Register write strobe |
| reg_kind | input | 2 | Register view select |
| reg_type | input | TYPE_W | Event kind select |
| reg_wdata | input | 2*NUM_CH | Write data; the upper half holds the mask write enables |
| reg_rdata | output | NUM_CH | Read data of the selected view |
| evt_summary | output | NUM_TYPES | Per-kind pending summary |
| irq | output | 1 | Interrupt request |

## Verification
Directed cases isolate single effects. One pulse on one channel shows that the correct bank bit latches. A clear colliding with a pulse shows that the set has priority. A half-enabled mask write shows that only enabled bits change. Memory-flagged channels receiving source and destination pulses show that suppression is selective by kind. Sparse random pulses are then mixed with random writes to every view and type, including out-of-range types. Under this load the summary, the interrupt and a read of a random view are compared each cycle against a bench model. This separates errors in bank indexing, in view decoding and in the reduction.

// File: rtl/dma_evt_pkg.sv
// Shared encodings for the DMA event interrupt controller.
// Assumes five event kinds in fixed summary-bit order.
package dma_evt_pkg;

    localparam int EV_TYPES   = 5;
    localparam int EV_XFER    = 0;
    localparam int EV_BLOCK   = 1;
    localparam int EV_SRC_TXN = 2;
    localparam int EV_DST_TXN = 3;
    localparam int EV_ERROR   = 4;

    typedef enum logic [1:0] {
        ACC_RAW    = 2'd0,
        ACC_STATUS = 2'd1,
        ACC_MASK   = 2'd2,
        ACC_CLEAR  = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/dma_evt_bank.sv
// One event bank: per-channel latched bits and mask bits, plus the pending view.
// Assumes the discard vector is already selected for this kind.
// A set in the same cycle as a clear takes priority.
module dma_evt_bank #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] hit_i,
    input  logic [NUM_CH-1:0] drop_i,
    input  logic              clr_we_i,
    input  logic              mask_we_i,
    input  logic [NUM_CH-1:0] wbits_i,
    input  logic [NUM_CH-1:0] wen_i,
    output logic [NUM_CH-1:0] raw_o,
    output logic [NUM_CH-1:0] mask_o,
    output logic [NUM_CH-1:0] status_o
);

    logic [NUM_CH-1:0] raw_q;
    logic [NUM_CH-1:0] mask_q;
    logic [NUM_CH-1:0] take;
    logic [NUM_CH-1:0] wipe;

    // Accepted pulses and requested clears for this cycle
    always_comb begin
        take = hit_i & ~drop_i;
        wipe = clr_we_i ? wbits_i : '0;
    end

    // Latched bits: clear first, then set so the set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else begin
            raw_q <= (raw_q & ~wipe) | take;
        end
    end

    // Mask bits: only channels whose enable bit is written change
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we_i) begin
            mask_q <= (mask_q & ~wen_i) | (wbits_i & wen_i);
        end
    end

    // Outputs of the bank
    always_comb begin
        raw_o    = raw_q;
        mask_o   = mask_q;
        status_o = raw_q & mask_q;
    end

endmodule

// File: rtl/dma_evt_regport.sv
// Register port decode: routes writes to one bank and muxes the selected read view.
// Assumes reg_type values at or above NUM_TYPES are unused and inert.
module dma_evt_regport
    import dma_evt_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int NUM_TYPES = 5,
    parameter int TYPE_W    = 3
) (
    input  logic                        reg_wr,
    input  logic [1:0]                  reg_kind,
    input  logic [TYPE_W-1:0]           reg_type,
    input  logic [2*NUM_CH-1:0]         reg_wdata,
    input  logic [NUM_TYPES*NUM_CH-1:0] raw_all,
    input  logic [NUM_TYPES*NUM_CH-1:0] mask_all,
    input  logic [NUM_TYPES*NUM_CH-1:0] status_all,
    output logic [NUM_TYPES-1:0]        clr_we,
    output logic [NUM_TYPES-1:0]        mask_we,
    output logic [NUM_CH-1:0]           wbits,
    output logic [NUM_CH-1:0]           wen,
    output logic [NUM_CH-1:0]           reg_rdata
);

    acc_kind_e kind;

    // Split write data into value and enable halves
    always_comb begin
        kind  = acc_kind_e'(reg_kind);
        wbits = reg_wdata[NUM_CH-1:0];
        wen   = reg_wdata[2*NUM_CH-1:NUM_CH];
    end

    // Per-kind write strobes; an unmatched type produces none
    always_comb begin
        clr_we  = '0;
        mask_we = '0;
        for (int k = 0; k < NUM_TYPES; k++) begin
            if (reg_wr && reg_type == TYPE_W'(k)) begin
                clr_we[k]  = (kind == ACC_CLEAR);
                mask_we[k] = (kind == ACC_MASK);
            end
        end
    end

    // Read mux over bank and view; the clear view and unknown types read 0
    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NUM_TYPES; k++) begin
            if (reg_type == TYPE_W'(k)) begin
                case (kind)
                    ACC_RAW:    reg_rdata = raw_all[k*NUM_CH +: NUM_CH];
                    ACC_STATUS: reg_rdata = status_all[k*NUM_CH +: NUM_CH];
                    ACC_MASK:   reg_rdata = mask_all[k*NUM_CH +: NUM_CH];
                    default:    reg_rdata = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/dma_evt_summary.sv
// Reduces each bank's pending bits to a summary bit and those to the interrupt.
// Assumes status_all is grouped by kind, NUM_CH bits each.
module dma_evt_summary #(
    parameter int NUM_CH    = 8,
    parameter int NUM_TYPES = 5
) (
    input  logic [NUM_TYPES*NUM_CH-1:0] status_all,
    output logic [NUM_TYPES-1:0]        summary,
    output logic                        irq
);

    // One OR tree per kind
    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_red
        assign summary[k] = |status_all[k*NUM_CH +: NUM_CH];
    end

    // Interrupt when any kind has something pending
    assign irq = |summary;

endmodule

// File: rtl/dma_evt_irq_ctrl.sv
// Top of the DMA event interrupt controller: one bank per event kind, register port
// and summary reduction. Assumes event pulses are one cycle wide and synchronous to clk.
module dma_evt_irq_ctrl
    import dma_evt_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int NUM_TYPES = EV_TYPES,
    parameter int TYPE_W    = $clog2(NUM_TYPES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_TYPES*NUM_CH-1:0] evt_pulse,
    input  logic [NUM_CH-1:0]           src_is_mem,
    input  logic [NUM_CH-1:0]           dst_is_mem,
    input  logic                        reg_wr,
    input  logic [1:0]                  reg_kind,
    input  logic [TYPE_W-1:0]           reg_type,
    input  logic [2*NUM_CH-1:0]         reg_wdata,
    output logic [NUM_CH-1:0]           reg_rdata,
    output logic [NUM_TYPES-1:0]        evt_summary,
    output logic                        irq
);

    localparam int FLAT_W = NUM_TYPES * NUM_CH;

    logic [FLAT_W-1:0]    raw_all;
    logic [FLAT_W-1:0]    mask_all;
    logic [FLAT_W-1:0]    status_all;
    logic [NUM_TYPES-1:0] clr_we;
    logic [NUM_TYPES-1:0] mask_we;
    logic [NUM_CH-1:0]    wbits;
    logic [NUM_CH-1:0]    wen;

    dma_evt_regport #(
        .NUM_CH    (NUM_CH),
        .NUM_TYPES (NUM_TYPES),
        .TYPE_W    (TYPE_W)
    ) u_port (
        .reg_wr     (reg_wr),
        .reg_kind   (reg_kind),
        .reg_type   (reg_type),
        .reg_wdata  (reg_wdata),
        .raw_all    (raw_all),
        .mask_all   (mask_all),
        .status_all (status_all),
        .clr_we     (clr_we),
        .mask_we    (mask_we),
        .wbits      (wbits),
        .wen        (wen),
        .reg_rdata  (reg_rdata)
    );

    // One bank per kind; the discard vector depends on the kind
    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_bank
        logic [NUM_CH-1:0] drop;
        if (k == EV_SRC_TXN) begin : g_src
            assign drop = src_is_mem;
        end else if (k == EV_DST_TXN) begin : g_dst
            assign drop = dst_is_mem;
        end else begin : g_none
            assign drop = '0;
        end

        dma_evt_bank #(.NUM_CH(NUM_CH)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit_i     (evt_pulse[k*NUM_CH +: NUM_CH]),
            .drop_i    (drop),
            .clr_we_i  (clr_we[k]),
            .mask_we_i (mask_we[k]),
            .wbits_i   (wbits),
            .wen_i     (wen),
            .raw_o     (raw_all[k*NUM_CH +: NUM_CH]),
            .mask_o    (mask_all[k*NUM_CH +: NUM_CH]),
            .status_o  (status_all[k*NUM_CH +: NUM_CH])
        );
    end

    dma_evt_summary #(
        .NUM_CH    (NUM_CH),
        .NUM_TYPES (NUM_TYPES)
    ) u_sum (
        .status_all (status_all),
        .summary    (evt_summary),
        .irq        (irq)
    );

endmodule

// File: rtl/dma_evt_irq_chk.sv
// Property checker for dma_evt_irq_ctrl, attached with bind.
// Assumes NUM_TYPES covers the source and destination transaction kinds.
module dma_evt_irq_chk
    import dma_evt_pkg::*;
#(
    parameter int NUM_CH    = 8,
    parameter int NUM_TYPES = 5,
    parameter int TYPE_W    = 3
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NUM_TYPES*NUM_CH-1:0] evt_pulse,
    input logic [NUM_CH-1:0]           src_is_mem,
    input logic [NUM_CH-1:0]           dst_is_mem,
    input logic                        reg_wr,
    input logic [1:0]                  reg_kind,
    input logic [TYPE_W-1:0]           reg_type,
    input logic [NUM_TYPES*NUM_CH-1:0] raw_all,
    input logic [NUM_TYPES*NUM_CH-1:0] mask_all,
    input logic [NUM_TYPES-1:0]        evt_summary,
    input logic                        irq
);

    logic [NUM_CH-1:0] raw_src;
    logic [NUM_CH-1:0] raw_dst;
    assign raw_src = raw_all[EV_SRC_TXN*NUM_CH +: NUM_CH];
    assign raw_dst = raw_all[EV_DST_TXN*NUM_CH +: NUM_CH];

    AST_RAW_RISE_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_all & ~$past(raw_all) & ~$past(evt_pulse)) == '0)); // R2

    AST_RAW_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_kind == 2'd3) |=> (($past(raw_all) & ~raw_all) == '0)); // R3

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_kind == 2'd2) |=> $stable(mask_all)); // R4

    AST_SRC_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_src & ~$past(raw_src) & $past(src_is_mem)) == '0)); // R6

    AST_DST_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((raw_dst & ~$past(raw_dst) & $past(dst_is_mem)) == '0)); // R6

    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(raw_all & mask_all))); // R8

    for (genvar k = 0; k < NUM_TYPES; k++) begin : g_sum
        AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
            evt_summary[k] == (|(raw_all[k*NUM_CH +: NUM_CH] & mask_all[k*NUM_CH +: NUM_CH]))); // R7
    end

endmodule

bind dma_evt_irq_ctrl dma_evt_irq_chk #(
    .NUM_CH    (NUM_CH),
    .NUM_TYPES (NUM_TYPES),
    .TYPE_W    (TYPE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_pulse   (evt_pulse),
    .src_is_mem  (src_is_mem),
    .dst_is_mem  (dst_is_mem),
    .reg_wr      (reg_wr),
    .reg_kind    (reg_kind),
    .reg_type    (reg_type),
    .raw_all     (raw_all),
    .mask_all    (mask_all),
    .evt_summary (evt_summary),
    .irq         (irq)
);

// File: tb/sim_dma_evt_irq_ctrl.sv
module sim_dma_evt_irq_ctrl;

    localparam int NCH = 8;
    localparam int NT  = 5;
    localparam int TW  = 3;
    localparam time TCK = 20ns;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NT*NCH-1:0] evt_pulse = '0;
    logic [NCH-1:0]  src_is_mem = '0;
    logic [NCH-1:0]  dst_is_mem = '0;
    logic            reg_wr = 1'b0;
    logic [1:0]      reg_kind = '0;
    logic [TW-1:0]   reg_type = '0;
    logic [2*NCH-1:0] reg_wdata = '0;
    logic [NCH-1:0]  reg_rdata;
    logic [NT-1:0]   evt_summary;
    logic            irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [NCH-1:0] m_raw  [NT];
    logic [NCH-1:0] m_mask [NT];

    always #(TCK/2) clk = ~clk;

    dma_evt_irq_ctrl #(.NUM_CH(NCH), .NUM_TYPES(NT), .TYPE_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .src_is_mem(src_is_mem), .dst_is_mem(dst_is_mem),
        .reg_wr(reg_wr), .reg_kind(reg_kind), .reg_type(reg_type),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_summary(evt_summary), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [NCH-1:0] exp_read(input logic [1:0] kd, input logic [TW-1:0] ty);
        if (ty >= TW'(NT)) return '0;
        case (kd)
            2'd0: return m_raw[ty];
            2'd1: return m_raw[ty] & m_mask[ty];
            2'd2: return m_mask[ty];
            default: return '0;
        endcase
    endfunction

    function automatic logic [NT-1:0] exp_sum();
        logic [NT-1:0] s;
        for (int k = 0; k < NT; k++) s[k] = |(m_raw[k] & m_mask[k]);
        return s;
    endfunction

    // Reference update for one clock edge
    task automatic model_edge(input logic [NT*NCH-1:0] p, input logic w, input logic [1:0] kd,
                              input logic [TW-1:0] ty, input logic [2*NCH-1:0] wd);
        for (int k = 0; k < NT; k++) begin
            logic [NCH-1:0] acc;
            logic [NCH-1:0] clr;
            acc = p[k*NCH +: NCH];
            if (k == 2) acc &= ~src_is_mem;
            if (k == 3) acc &= ~dst_is_mem;
            clr = (w && kd == 2'd3 && ty == TW'(k)) ? wd[NCH-1:0] : '0;
            m_raw[k] = (m_raw[k] & ~clr) | acc;
            if (w && kd == 2'd2 && ty == TW'(k))
                m_mask[k] = (m_mask[k] & ~wd[2*NCH-1:NCH]) | (wd[NCH-1:0] & wd[2*NCH-1:NCH]);
        end
    endtask

    // One cycle: drive at the falling edge, model at rising, compare at next falling
    task automatic step(input logic [NT*NCH-1:0] p, input logic w, input logic [1:0] kd,
                        input logic [TW-1:0] ty, input logic [2*NCH-1:0] wd);
        evt_pulse = p; reg_wr = w; reg_kind = kd; reg_type = ty; reg_wdata = wd;
        @(posedge clk);
        model_edge(p, w, kd, ty, wd);
        @(negedge clk);
        evt_pulse = '0; reg_wr = 1'b0;
        #1;
        chk("R7 summary", 32'(evt_summary), 32'(exp_sum()));
        chk("R8 irq", 32'(irq), 32'(|exp_sum()));
    endtask

    task automatic rd(input logic [1:0] kd, input logic [TW-1:0] ty, input string req);
        reg_kind = kd; reg_type = ty;
        #1;
        chk(req, 32'(reg_rdata), 32'(exp_read(kd, ty)));
    endtask

    function automatic logic [NT*NCH-1:0] one(input int k, input int c);
        logic [NT*NCH-1:0] v = '0;
        v[k*NCH + c] = 1'b1;
        return v;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        for (int k = 0; k < NT; k++) begin m_raw[k] = '0; m_mask[k] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 summary", 32'(evt_summary), 0);
        chk("R1 irq", 32'(irq), 0);
        for (int k = 0; k < NT; k++) begin
            rd(2'd0, TW'(k), "R1 raw");
            rd(2'd2, TW'(k), "R1 mask");
        end
        // R2: pulse latches and holds with mask still 0
        step(one(0, 3), 0, 0, 0, 0);
        rd(2'd0, 0, "R2 raw set");
        chk("R2 irq masked", 32'(irq), 0);
        step('0, 0, 0, 0, 0);
        rd(2'd0, 0, "R2 raw hold");
        // R4: enable all mask bits of kind 0, then partial-enable write
        step('0, 1, 2'd2, 0, {8'hFF, 8'hFF});
        rd(2'd2, 0, "R4 mask full");
        rd(2'd1, 0, "R5 status");
        chk("R8 irq asserted", 32'(irq), 1);
        step('0, 1, 2'd2, 0, {8'h0F, 8'hA0});
        rd(2'd2, 0, "R4 mask partial");
        rd(2'd1, 0, "R5 status after mask");
        // R3: clear with zero bits is inert, set wins over clear
        step('0, 1, 2'd3, 0, {8'h00, 8'h00});
        rd(2'd0, 0, "R3 zero clear");
        step(one(0, 3), 1, 2'd3, 0, {8'h00, 8'h08});
        rd(2'd0, 0, "R3 set beats clear");
        step('0, 1, 2'd3, 0, {8'h00, 8'h08});
        rd(2'd0, 0, "R3 clear");
        // R6: memory endpoints discard transaction pulses of the matching side only
        src_is_mem = 8'hF0; dst_is_mem = 8'h0F;
        step({8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00}, 0, 0, 0, 0);
        rd(2'd0, 3'd2, "R6 src discard");
        rd(2'd0, 3'd3, "R6 dst discard");
        // R9: inert writes and reads
        step('0, 1, 2'd3, 3'd5, 16'hFFFF);
        step('0, 1, 2'd0, 3'd2, 16'hFFFF);
        step('0, 1, 2'd1, 3'd3, 16'hFFFF);
        rd(2'd0, 3'd2, "R9 raw after inert writes");
        rd(2'd0, 3'd3, "R9 raw dst after inert writes");
        rd(2'd3, 3'd2, "R9 clear view reads 0");
        rd(2'd0, 3'd6, "R9 bad type reads 0");
        // Error kind: mask and pulse show on summary bit 4
        step('0, 1, 2'd2, 3'd4, {8'h01, 8'h01});
        step(one(4, 0), 0, 0, 0, 0);
        chk("R7 error bit", 32'(evt_summary[4]), 1);
        // Random phase
        for (int i = 0; i < 2000; i++) begin
            logic [NT*NCH-1:0] p;
            logic w;
            if (i % 50 == 0) begin
                src_is_mem = NCH'($urandom); dst_is_mem = NCH'($urandom);
            end
            p = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
            w = ($urandom % 10) < 3;
            step(p, w, 2'($urandom), TW'($urandom % 6), 16'($urandom));
            rd(2'($urandom), TW'($urandom % 6), "R5 R9 random read");
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule